// File: doc/BRIEF.md
# Single-Trit Ternary Function-Select ALU

This block is a purely combinational arithmetic logic unit that works on one ternary digit (trit) at a time. Each trit travels on a 2-bit binary field: 2'b00 is 0, 2'b01 is 1 and 2'b10 is 2. Two operand trits, a carry/borrow trit and two select trits enter the block. It returns one result trit and one secondary trit that holds a carry or a borrow.

The two select trits are decoded into nine one-hot function enables. The decoder ANDs selection literals, which means it takes the minimum of them. A literal of x for value v is 2 when x equals v and 0 otherwise. Every processing lane computes its result all the time. The enables gate exactly one lane onto the outputs through an AND-OR merge.

The arithmetic lanes are add with carry, subtract with borrow and multiply with carry. The logic lanes use max-min algebra: AND is min, OR is max, and both have complemented forms. There is also a ternary inverter and a pass-through of operand A. Wider words are built by chaining instances outside the block.

Top module: `ternary_alu`

## Requirements
- R1: An input field of 2'b11 on any input (opa_i, opb_i, cin_i, sel_hi_i, sel_lo_i) is treated exactly as the trit 0.
- R2: The lane number s = 3*sel_hi_i + sel_lo_i picks one lane: 0 add, 1 subtract, 2 multiply, 3 min, 4 max, 5 inverted min, 6 inverted max, 7 invert A, 8 pass A. Exactly one lane enable is active for every input.
- R3: Add lane: with T = A + B + C, res_o = T mod 3 and cout_o = T div 3. T can reach 6, which gives cout_o = 2.
- R4: Subtract lane: with D = A - B - C, cout_o is the smallest k in {0,1,2} with D + 3k >= 0, and res_o = D + 3k.
- R5: Multiply lane: res_o = (A*B) mod 3 and cout_o = (A*B) div 3. cout_o is 1 only for 2*2, and the product is then 1. cin_i has no effect.
- R6: Lane 3 gives min(A,B) and lane 4 gives max(A,B).
- R7: Lane 5 gives 2 - min(A,B) and lane 6 gives 2 - max(A,B).
- R8: Lane 7 gives 2 - A and lane 8 gives A. opb_i has no effect on either lane.
- R9: On lanes 3 to 8, cout_o is 0 and cin_i has no effect on res_o.
- R10: res_o and cout_o never carry the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 2 | Operand A trit |
| opb_i | input | 2 | Operand B trit |
| cin_i | input | 2 | Carry-in (add) or borrow-in (subtract) trit |
| sel_hi_i | input | 2 | High select trit |
| sel_lo_i | input | 2 | Low select trit |
| res_o | output | 2 | Result trit of the selected lane |
| cout_o | output | 2 | Carry-out or borrow-out trit, 0 on logic lanes |

## Verification
Some cases are hard to reach by chance: a subtract that needs a borrow of two (0 - 2 - 2), an add whose carry is two (2 + 2 + 2), and a select whose high trit carries the illegal code, which must fall back to lane 0, 1 or 2. The stimulus sweeps every 2-bit code on all five inputs, including 2'b11. That covers these corners, and every lane is seen with every operand and carry value. For each lane, the results the bench expects depend only on the inputs that lane is allowed to use. So a lane that wrongly reacts to cin_i or opb_i shows up as a mismatch.

// File: rtl/ternary_alu_pkg.sv
package ternary_alu_pkg;

    localparam int TRIT_W    = 2;
    localparam int RADIX     = 3;
    localparam int SEL_TRITS = 2;
    localparam int NUM_LANES = RADIX * RADIX;
    localparam int ARITH_LANES = 3;

    typedef logic [TRIT_W-1:0] trit_t;

    typedef enum logic [3:0] {
        LN_ADD  = 4'd0,
        LN_SUB  = 4'd1,
        LN_MUL  = 4'd2,
        LN_MIN  = 4'd3,
        LN_MAX  = 4'd4,
        LN_NMIN = 4'd5,
        LN_NMAX = 4'd6,
        LN_INV  = 4'd7,
        LN_PASS = 4'd8
    } lane_e;

    // Fold the unused code onto zero.
    function automatic trit_t trit_clean(trit_t x);
        return (x == 2'b11) ? 2'b00 : x;
    endfunction

    // Selection literal: 2 on a match, 0 otherwise.
    function automatic trit_t trit_lit(trit_t x, trit_t v);
        return (x == v) ? 2'd2 : 2'd0;
    endfunction

    function automatic trit_t trit_min(trit_t a, trit_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic trit_t trit_max(trit_t a, trit_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic trit_t trit_inv(trit_t a);
        return 2'd2 - a;
    endfunction

endpackage

// File: rtl/tern_sel_decode.sv
module tern_sel_decode
    import ternary_alu_pkg::*;
#(
    parameter int LANES = NUM_LANES
) (
    input  trit_t            sel_hi,
    input  trit_t            sel_lo,
    output logic [LANES-1:0] lane_en
);
    localparam int COLS = RADIX;

    // Each enable is the min of two selection literals, which is 2 only
    // when both select trits match the lane's digits.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam trit_t HI_V = trit_t'(g / COLS);
        localparam trit_t LO_V = trit_t'(g % COLS);
        assign lane_en[g] = (trit_min(trit_lit(sel_hi, HI_V),
                                      trit_lit(sel_lo, LO_V)) == 2'd2);
    end

endmodule

// File: rtl/tern_arith_lanes.sv
module tern_arith_lanes
    import ternary_alu_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    input  trit_t c,
    output trit_t sum,
    output trit_t sum_cy,
    output trit_t diff,
    output trit_t diff_bw,
    output trit_t prod,
    output trit_t prod_cy
);
    logic [2:0]        add_tot;
    logic signed [3:0] sub_raw;
    logic signed [3:0] sub_fix;
    logic [3:0]        mul_raw;

    // Add: total 0..6 split into digit and carry.
    always_comb begin
        add_tot = 3'(a) + 3'(b) + 3'(c);
        unique case (add_tot)
            3'd0, 3'd3, 3'd6: sum = 2'd0;
            3'd1, 3'd4:       sum = 2'd1;
            default:          sum = 2'd2;
        endcase
        if (add_tot >= 3'd6)      sum_cy = 2'd2;
        else if (add_tot >= 3'd3) sum_cy = 2'd1;
        else                      sum_cy = 2'd0;
    end

    // Subtract: raw difference -4..2, borrow of 0, 1 or 2 digits.
    always_comb begin
        sub_raw = $signed({2'b00, a}) - $signed({2'b00, b}) - $signed({2'b00, c});
        if (sub_raw >= 4'sd0) begin
            diff_bw = 2'd0;
            sub_fix = sub_raw;
        end else if (sub_raw >= -4'sd3) begin
            diff_bw = 2'd1;
            sub_fix = sub_raw + 4'sd3;
        end else begin
            diff_bw = 2'd2;
            sub_fix = sub_raw + 4'sd6;
        end
        diff = sub_fix[1:0];
    end

    // Multiply: product 0..4.
    always_comb begin
        mul_raw = 4'(a) * 4'(b);
        unique case (mul_raw)
            4'd1, 4'd4: prod = 2'd1;
            4'd2:       prod = 2'd2;
            default:    prod = 2'd0;
        endcase
        prod_cy = (mul_raw >= 4'd3) ? 2'd1 : 2'd0;
    end

endmodule

// File: rtl/tern_logic_lanes.sv
module tern_logic_lanes
    import ternary_alu_pkg::*;
(
    input  trit_t a,
    input  trit_t b,
    output trit_t lo_min,
    output trit_t lo_max,
    output trit_t lo_nmin,
    output trit_t lo_nmax,
    output trit_t lo_inv,
    output trit_t lo_pass
);
    always_comb begin
        lo_min  = trit_min(a, b);
        lo_max  = trit_max(a, b);
        lo_nmin = trit_inv(lo_min);
        lo_nmax = trit_inv(lo_max);
        lo_inv  = trit_inv(a);
        lo_pass = a;
    end

endmodule

// File: rtl/ternary_alu.sv
module ternary_alu
    import ternary_alu_pkg::*;
(
    input  logic [1:0] opa_i,
    input  logic [1:0] opb_i,
    input  logic [1:0] cin_i,
    input  logic [1:0] sel_hi_i,
    input  logic [1:0] sel_lo_i,
    output logic [1:0] res_o,
    output logic [1:0] cout_o
);
    trit_t opa_c, opb_c, cin_c, sel_hi_c, sel_lo_c;
    logic [NUM_LANES-1:0] lane_en;
    trit_t lane_res [NUM_LANES];
    trit_t lane_cy  [ARITH_LANES];
    trit_t res_mask [NUM_LANES];
    trit_t cy_mask  [ARITH_LANES];

    always_comb begin
        opa_c    = trit_clean(opa_i);
        opb_c    = trit_clean(opb_i);
        cin_c    = trit_clean(cin_i);
        sel_hi_c = trit_clean(sel_hi_i);
        sel_lo_c = trit_clean(sel_lo_i);
    end

    tern_sel_decode #(.LANES(NUM_LANES)) dec_i (
        .sel_hi  (sel_hi_c),
        .sel_lo  (sel_lo_c),
        .lane_en (lane_en)
    );

    tern_arith_lanes arith_i (
        .a       (opa_c),
        .b       (opb_c),
        .c       (cin_c),
        .sum     (lane_res[LN_ADD]),
        .sum_cy  (lane_cy[LN_ADD]),
        .diff    (lane_res[LN_SUB]),
        .diff_bw (lane_cy[LN_SUB]),
        .prod    (lane_res[LN_MUL]),
        .prod_cy (lane_cy[LN_MUL])
    );

    tern_logic_lanes logic_i (
        .a       (opa_c),
        .b       (opb_c),
        .lo_min  (lane_res[LN_MIN]),
        .lo_max  (lane_res[LN_MAX]),
        .lo_nmin (lane_res[LN_NMIN]),
        .lo_nmax (lane_res[LN_NMAX]),
        .lo_inv  (lane_res[LN_INV]),
        .lo_pass (lane_res[LN_PASS])
    );

    // Gate each lane by its enable, then OR the gated lanes together.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_res_gate
        assign res_mask[g] = lane_res[g] & {TRIT_W{lane_en[g]}};
    end
    for (genvar g = 0; g < ARITH_LANES; g++) begin : g_cy_gate
        assign cy_mask[g] = lane_cy[g] & {TRIT_W{lane_en[g]}};
    end

    always_comb begin
        res_o = '0;
        for (int i = 0; i < NUM_LANES; i++) res_o |= res_mask[i];
        cout_o = '0;
        for (int i = 0; i < ARITH_LANES; i++) cout_o |= cy_mask[i];
    end

endmodule

// File: rtl/ternary_alu_chk.sv
module ternary_alu_chk
    import ternary_alu_pkg::*;
(
    input logic [1:0]           opa_c,
    input logic [1:0]           opb_c,
    input logic [1:0]           cin_c,
    input logic [NUM_LANES-1:0] lane_en,
    input logic [1:0]           res_o,
    input logic [1:0]           cout_o
);
    always_comb begin
        // R2: exactly one lane is enabled
        a_r2_one_lane: assert ($onehot(lane_en));
        // R10: no output carries the unused code
        a_r10_res_legal: assert (res_o != 2'b11);
        a_r10_cout_legal: assert (cout_o != 2'b11);
        // R9: logic lanes never raise the secondary output
        if (|lane_en[NUM_LANES-1:ARITH_LANES])
            a_r9_logic_no_carry: assert (cout_o == 2'd0);
        // R3: carry and digit recombine to the operand total
        if (lane_en[LN_ADD])
            a_r3_add_total: assert (3 * int'(cout_o) + int'(res_o)
                                    == int'(opa_c) + int'(opb_c) + int'(cin_c));
        // R4: difference minus the borrowed digits equals A - B - C
        if (lane_en[LN_SUB])
            a_r4_sub_total: assert (int'(res_o) - 3 * int'(cout_o)
                                    == int'(opa_c) - int'(opb_c) - int'(cin_c));
        // R5: a multiply carry comes only with product digit 1
        if (lane_en[LN_MUL] && cout_o != 2'd0)
            a_r5_mul_carry: assert (cout_o == 2'd1 && res_o == 2'd1);
    end

endmodule

bind ternary_alu ternary_alu_chk chk_i (
    .opa_c   (opa_c),
    .opb_c   (opb_c),
    .cin_c   (cin_c),
    .lane_en (lane_en),
    .res_o   (res_o),
    .cout_o  (cout_o)
);

// File: tb/ternary_alu_tb_top.sv
module ternary_alu_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0] opa, opb, cin, shi, slo;
    logic [1:0] res, cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ternary_alu dut_i (
        .opa_i    (opa),
        .opb_i    (opb),
        .cin_i    (cin),
        .sel_hi_i (shi),
        .sel_lo_i (slo),
        .res_o    (res),
        .cout_o   (cout)
    );

    function automatic int fold(logic [1:0] x);
        return (x == 2'b11) ? 0 : int'(x);
    endfunction

    task automatic check(string tag, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (a=%0d b=%0d c=%0d hi=%0d lo=%0d)",
                     tag, act, exp_v, opa, opb, cin, shi, slo);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; cin = '0; shi = '0; slo = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // Idle inputs select the add lane with all-zero operands (R2, R3)
        check("R3 idle res", int'(res), 0);
        check("R3 idle cout", int'(cout), 0);

        for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
        for (int ic = 0; ic < 4; ic++)
        for (int ih = 0; ih < 4; ih++)
        for (int il = 0; il < 4; il++) begin
            int a, b, c, s, er, ec, t, k;
            string tag;
            @(negedge clk);
            opa = 2'(ia); opb = 2'(ib); cin = 2'(ic); shi = 2'(ih); slo = 2'(il);
            a = fold(opa); b = fold(opb); c = fold(cin);
            s = 3 * fold(shi) + fold(slo);
            ec = 0;
            case (s)
                0: begin t = a + b + c; er = t % 3; ec = t / 3; tag = "R3 add"; end
                1: begin
                       t = a - b - c; k = 0;
                       while (t + 3 * k < 0) k++;
                       er = t + 3 * k; ec = k; tag = "R4 sub";
                   end
                2: begin er = (a * b) % 3; ec = (a * b) / 3; tag = "R5 mul"; end
                3: begin er = (a < b) ? a : b; tag = "R6 min"; end
                4: begin er = (a > b) ? a : b; tag = "R6 max"; end
                5: begin er = 2 - ((a < b) ? a : b); tag = "R7 nmin"; end
                6: begin er = 2 - ((a > b) ? a : b); tag = "R7 nmax"; end
                7: begin er = 2 - a; tag = "R8 inv"; end
                default: begin er = a; tag = "R8 pass"; end
            endcase
            if (ia == 3 || ib == 3 || ic == 3 || ih == 3 || il == 3)
                tag = {tag, " R1 folded"};
            if (s >= 3) tag = {tag, " R9"};
            tag = {tag, " R2"};
            #2;
            check({tag, " res"}, int'(res), er);
            check({tag, " cout"}, int'(cout), ec);
            // R10: outputs stay within legal codes
            check("R10 legal", int'(res == 2'b11 || cout == 2'b11), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule